// File: doc/BRIEF.md
# Mezzanine Interrupt Aggregation Controller

This block gathers the interrupt request lines of six mezzanine module slots, two lines per slot, and presents them to a host. After a two-flop synchroniser each request line feeds a live status bit. The status bits merge onto one active-low interrupt output that a global enable gates. A summary bit tells software whether this card is one of the requesters on a shared host interrupt line. The status image follows the modules: no host write can clear a bit, and a bit drops only when its module withdraws the request. The block sets no priority among requests. Every set bit is reported at once, and software picks the order.

The host reaches the block through a simple register port. The host gives a one-cycle request with a read/write flag and an address. The block answers with a one-cycle done pulse and the read data. When address bit 5 is set, the access targets the interrupt window of the slot given in address bits 4:2. In that case the block runs an interrupt-acknowledge cycle on the module bus. It raises the select strobe of that slot and waits for the module's acknowledge. It then captures the low byte the module drives as the vector and ends the host read.

Top module: `mzi_irq_hub`

## Requirements
- R1: Request line `s*2+l` (slot `s`, line `l`) appears in status bit `s*2+l` three clock edges after it changes. Two edges are for the synchroniser and one is for the status register.
- R2: A status bit clears only after its request line drops. A host write to the status register (address 0) changes no status bit.
- R3: A read of the status register returns zero in bits 15:12.
- R4: `irq_n` is low exactly when the enable bit (bit 0 of the control register at address 1, writable) is 1 and at least one status bit is set. While the enable is 0, `irq_n` stays high.
- R5: Bit 1 of the control register reads 1 whenever any status bit is set, whatever the enable is. Bits 15:2 read zero.
- R6: When several request lines are active, all of their status bits read as set together, with no masking or priority.
- R7: A host read with address bit 5 set and slot field 0 to 5 asserts only the select line of that slot. The select line rises on the edge after the request and holds until that module acknowledges.
- R8: On the edge where the selected module's acknowledge is seen, the select line drops. `host_done` pulses in the next cycle, and `host_rdata` holds the module's data bits 7:0 with bits 15:8 zero.
- R9: A register read or write (address bit 5 clear) gets `host_done` exactly one cycle after the request, and a write returns zero data.
- R10: After reset the status bits and the enable are 0 and `irq_n` is high.
- R11: A window read whose slot field is 6 or 7 asserts no select line and completes one cycle later with data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Bit 5 selects window; bits 4:2 slot; bit 0 register select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| mod_irq | input | 12 | Module request lines, bit s*2+l |
| mod_isel | output | 6 | Per-slot interrupt-acknowledge select |
| mod_ack | input | 6 | Per-slot module acknowledge |
| mod_data | input | 16 | Module bus data lines |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Each result has its own due cycle. A register access completes one cycle after its request. A request edge reaches the status bits and `irq_n` three edges later. A window read completes one cycle after the acknowledge edge, which is two cycles plus the module's wait time after the request. The driver stamps each access with its issue cycle and pushes the expected data and latency. The monitor samples at falling edges, measures the latency of every done pulse, and compares it with the pushed latency. The bench checks `irq_n` at each falling edge across the three-edge request path, so a result that comes early or late is reported.

// File: rtl/mzi_pkg.sv
package mzi_pkg;
   typedef enum logic [0:0] {
      SQ_IDLE   = 1'b0,
      SQ_STROBE = 1'b1
   } sq_state_t;
endpackage

// File: rtl/mzi_sync.sv
module mzi_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mzi_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) pipe[0] <= '0;
            else     pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mzi_regs.sv
module mzi_regs #(
   parameter int NREQ   = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc,
   input  logic              we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NREQ-1:0]   irq_sync,
   output logic [NREQ-1:0]   status,
   output logic              int_en,
   output logic              irq_n,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic [NREQ-1:0]   status_q;
   logic              int_en_q;
   logic              summary;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] ctrl_word;

   always_ff @(posedge clk) begin
      if (rst) status_q <= '0;
      else     status_q <= irq_sync;
   end

   assign summary = |status_q;

   if (NREQ == DATA_W) begin : g_full
      assign stat_word = status_q;
   end else begin : g_pad
      assign stat_word = {{(DATA_W-NREQ){1'b0}}, status_q};
   end

   assign ctrl_word = {{(DATA_W-2){1'b0}}, summary, int_en_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         int_en_q <= 1'b0;
         rdata    <= '0;
         done     <= 1'b0;
      end else begin
         done  <= acc;
         rdata <= '0;
         if (acc && we && reg_sel) int_en_q <= wdata[0];
         if (acc && !we) rdata <= reg_sel ? ctrl_word : stat_word;
      end
   end

   assign status = status_q;
   assign int_en = int_en_q;
   assign irq_n  = ~(int_en_q & summary);
endmodule

// File: rtl/mzi_iack.sv
module mzi_iack
   import mzi_pkg::*;
#(
   parameter int NUM_SLOTS = 6,
   parameter int DATA_W    = 16,
   parameter int VEC_W     = 8,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [SLOT_W-1:0]    slot_idx,
   input  logic [NUM_SLOTS-1:0] mod_ack,
   input  logic [DATA_W-1:0]    mod_data,
   output logic [NUM_SLOTS-1:0] mod_isel,
   output logic [DATA_W-1:0]    vec_out,
   output logic                 done,
   output logic                 busy
);
   sq_state_t            state_q;
   logic [NUM_SLOTS-1:0] sel_q;
   logic                 slot_ok;
   logic                 ack_hit;

   assign slot_ok = {1'b0, slot_idx} < (SLOT_W+1)'(NUM_SLOTS);
   assign ack_hit = |(mod_ack & sel_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SQ_IDLE;
         sel_q   <= '0;
         vec_out <= '0;
         done    <= 1'b0;
      end else begin
         done    <= 1'b0;
         vec_out <= '0;
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  if (slot_ok) begin
                     for (int i = 0; i < NUM_SLOTS; i++)
                        sel_q[i] <= (slot_idx == SLOT_W'(i));
                     state_q <= SQ_STROBE;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            SQ_STROBE: begin
               if (ack_hit) begin
                  vec_out <= {{(DATA_W-VEC_W){1'b0}}, mod_data[VEC_W-1:0]};
                  sel_q   <= '0;
                  done    <= 1'b1;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mod_isel = sel_q;
   assign busy     = (state_q != SQ_IDLE);
endmodule

// File: rtl/mzi_irq_hub.sv
module mzi_irq_hub #(
   parameter int NUM_SLOTS   = 6,
   parameter int LINES       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 16,
   parameter int VEC_W       = 8,
   parameter int ADDR_W      = 6,
   parameter int SLOT_LSB    = 2,
   localparam int NREQ       = NUM_SLOTS * LINES,
   localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 host_req,
   input  logic                 host_we,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   output logic                 host_done,
   input  logic [NREQ-1:0]      mod_irq,
   output logic [NUM_SLOTS-1:0] mod_isel,
   input  logic [NUM_SLOTS-1:0] mod_ack,
   input  logic [DATA_W-1:0]    mod_data,
   output logic                 irq_n
);
   if (NUM_SLOTS < 2)                    begin : g_bad_slots $error("NUM_SLOTS < 2"); end
   if (NREQ > DATA_W)                    begin : g_bad_nreq  $error("NREQ exceeds DATA_W"); end
   if (VEC_W > DATA_W || DATA_W < 2)     begin : g_bad_data  $error("bad DATA_W/VEC_W"); end
   if (SLOT_LSB + SLOT_W > ADDR_W - 1 || SLOT_LSB < 1)
                                         begin : g_bad_addr  $error("slot field misplaced"); end

   logic [NREQ-1:0]   irq_sync;
   logic [NREQ-1:0]   status;
   logic              int_en;
   logic              busy;
   logic              win;
   logic              reg_acc;
   logic              iack_go;
   logic [DATA_W-1:0] reg_rdata;
   logic [DATA_W-1:0] vec_rdata;
   logic              reg_done;
   logic              iack_done;

   assign win     = host_addr[ADDR_W-1];
   assign reg_acc = host_req && !busy && (!win || host_we);
   assign iack_go = host_req && !busy && win && !host_we;

   mzi_sync #(.W(NREQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (mod_irq),
      .q   (irq_sync)
   );

   mzi_regs #(.NREQ(NREQ), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .acc      (reg_acc),
      .we       (host_we && !win),
      .reg_sel  (host_addr[0]),
      .wdata    (host_wdata),
      .irq_sync (irq_sync),
      .status   (status),
      .int_en   (int_en),
      .irq_n    (irq_n),
      .rdata    (reg_rdata),
      .done     (reg_done)
   );

   mzi_iack #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_iack (
      .clk      (clk),
      .rst      (rst),
      .start    (iack_go),
      .slot_idx (host_addr[SLOT_LSB +: SLOT_W]),
      .mod_ack  (mod_ack),
      .mod_data (mod_data),
      .mod_isel (mod_isel),
      .vec_out  (vec_rdata),
      .done     (iack_done),
      .busy     (busy)
   );

   assign host_done  = reg_done | iack_done;
   assign host_rdata = reg_rdata | vec_rdata;
endmodule

// File: rtl/mzi_irq_hub_chk.sv
module mzi_irq_hub_chk #(
   parameter int NUM_SLOTS = 6,
   parameter int ADDR_W    = 6,
   parameter int SLOT_LSB  = 2,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 host_req,
   input logic                 host_we,
   input logic [ADDR_W-1:0]    host_addr,
   input logic                 host_done,
   input logic [NUM_SLOTS-1:0] mod_isel,
   input logic [NUM_SLOTS-1:0] mod_ack,
   input logic                 irq_n,
   input logic                 int_en,
   input logic                 busy
);
   logic bad_slot;
   assign bad_slot = {1'b0, host_addr[SLOT_LSB +: SLOT_W]} >= (SLOT_W+1)'(NUM_SLOTS);

   // R7
   sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mod_isel));

   // R7
   sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((|mod_isel) && !(|(mod_isel & mod_ack))) |=> $stable(mod_isel));

   // R8
   ack_done_chk: assert property (@(posedge clk) disable iff (rst)
      (|(mod_isel & mod_ack)) |=> (host_done && (mod_isel == '0)));

   // R9
   reg_done_chk: assert property (@(posedge clk) disable iff (rst)
      (host_req && !busy && !host_addr[ADDR_W-1]) |=> host_done);

   // R4
   irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
      !int_en |-> irq_n);

   // R11
   bad_slot_chk: assert property (@(posedge clk) disable iff (rst)
      (host_req && !busy && !host_we && host_addr[ADDR_W-1] && bad_slot)
      |=> (host_done && (mod_isel == '0)));
endmodule

bind mzi_irq_hub mzi_irq_hub_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W),
   .SLOT_LSB  (SLOT_LSB)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .host_req  (host_req),
   .host_we   (host_we),
   .host_addr (host_addr),
   .host_done (host_done),
   .mod_isel  (mod_isel),
   .mod_ack   (mod_ack),
   .irq_n     (irq_n),
   .int_en    (int_en),
   .busy      (busy)
);

// File: tb/tb_mzi_irq_hub.sv
`timescale 1ns/1ps
module tb_mzi_irq_hub;
   localparam int NS = 6;
   localparam int NR = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_done;
   logic [NR-1:0] mod_irq = '0;
   logic [NS-1:0] mod_isel;
   logic [NS-1:0] mod_ack = '0;
   logic [15:0] mod_data = '0;
   logic        irq_n;

   always #2.5 clk = ~clk;

   mzi_irq_hub dut (
      .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_done(host_done), .mod_irq(mod_irq), .mod_isel(mod_isel),
      .mod_ack(mod_ack), .mod_data(mod_data), .irq_n(irq_n)
   );

   typedef struct {
      logic [15:0] val;
      int          lat;
      int          issue;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   int   ack_delay = 0;
   logic [NS-1:0] exp_sel = '0;
   int   wcnt = 0;
   bit   ended = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: pops expected items as done pulses arrive
   always @(negedge clk) begin
      if (!rst && host_done) begin
         if (exp_q.size() == 0) begin
            check(0, "R9 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(host_rdata == e.val, e.tag, host_rdata, e.val);
            check((cyc - e.issue) == e.lat, {e.tag, " latency"}, cyc - e.issue, e.lat);
         end
      end
   end

   // module-bus model: acknowledges a held select after ack_delay cycles
   always @(negedge clk) begin
      if (rst) begin
         mod_ack <= '0;
         wcnt    <= 0;
      end else if (|mod_isel) begin
         if (mod_isel != exp_sel) check(0, "R7 select", mod_isel, exp_sel);
         if (wcnt == ack_delay) begin
            mod_ack <= mod_isel;
            for (int i = 0; i < NS; i++)
               if (mod_isel[i]) mod_data <= {8'hEE, 8'h30 + 8'(i)};
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         mod_ack <= '0;
         wcnt    <= 0;
      end
   end

   task automatic access(input bit we, input logic [5:0] a, input logic [15:0] wd,
                         input logic [15:0] ev, input int lat, input string tag);
      exp_t e;
      @(negedge clk);
      host_req   = 1'b1;
      host_we    = we;
      host_addr  = a;
      host_wdata = wd;
      e.val = ev; e.lat = lat; e.issue = cyc; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      host_req = 1'b0;
      host_we  = 1'b0;
      wait (exp_q.size() == 0);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      check(irq_n == 1'b1, "R10 irq_n after reset", irq_n, 1);
      access(0, 6'h00, 16'h0, 16'h0000, 1, "R10 status after reset");
      access(0, 6'h01, 16'h0, 16'h0000, 1, "R10 ctrl after reset");

      // one request, interrupts disabled
      mod_irq[3] = 1'b1;
      wait_cyc(4);
      check(irq_n == 1'b1, "R4 masked irq_n", irq_n, 1);
      access(0, 6'h01, 16'h0, 16'h0002, 1, "R5 summary while disabled");
      access(0, 6'h00, 16'h0, 16'h0008, 1, "R1 R3 status slot1 line1");

      // enable, check irq_n
      access(1, 6'h01, 16'hFFFF, 16'h0000, 1, "R9 write ctrl");
      @(negedge clk);
      check(irq_n == 1'b0, "R4 irq_n enabled", irq_n, 0);
      access(0, 6'h01, 16'h0, 16'h0003, 1, "R5 ctrl with enable");

      // writes do not clear status
      access(1, 6'h00, 16'hFFFF, 16'h0000, 1, "R9 write status");
      access(0, 6'h00, 16'h0, 16'h0008, 1, "R2 status after write");

      // several at once
      mod_irq[0]  = 1'b1;
      mod_irq[11] = 1'b1;
      wait_cyc(4);
      access(0, 6'h00, 16'h0, 16'h0809, 1, "R6 multiple bits");

      // withdraw all
      mod_irq = '0;
      wait_cyc(4);
      access(0, 6'h00, 16'h0, 16'h0000, 1, "R2 cleared by module");
      check(irq_n == 1'b1, "R4 irq_n idle", irq_n, 1);

      // R1 three-edge timing, enable is on
      @(negedge clk);
      mod_irq[5] = 1'b1;
      @(negedge clk);
      check(irq_n == 1'b1, "R1 edge1", irq_n, 1);
      @(negedge clk);
      check(irq_n == 1'b1, "R1 edge2", irq_n, 1);
      @(negedge clk);
      check(irq_n == 1'b0, "R1 edge3", irq_n, 0);
      mod_irq = '0;
      wait_cyc(4);

      // interrupt-acknowledge cycles
      ack_delay = 3;
      exp_sel   = 6'b010000;
      access(0, 6'h20 | (6'd4 << 2), 16'h0, 16'h0034, 2 + 3, "R7 R8 iack slot4");
      ack_delay = 0;
      exp_sel   = 6'b000001;
      access(0, 6'h20, 16'h0, 16'h0030, 2, "R8 iack slot0 fast");
      ack_delay = 1;
      exp_sel   = 6'b100000;
      access(0, 6'h20 | (6'd5 << 2), 16'h0, 16'h0035, 3, "R8 iack slot5");
      check(mod_isel == '0, "R8 select released", mod_isel, 0);

      // invalid slot
      exp_sel = '0;
      access(0, 6'h20 | (6'd7 << 2), 16'h0, 16'h0000, 1, "R11 slot7");
      check(mod_isel == '0, "R11 no select", mod_isel, 0);
      access(0, 6'h20 | (6'd6 << 2), 16'h0, 16'h0000, 1, "R11 slot6");

      wait_cyc(2);
      finish_run();
   end
endmodule